// File: doc/BRIEF.md
# Interrupt Gating and Service Control

This block decides, cycle by cycle, whether the processor core may be offered an interrupt. Six peripheral groups and one group of system sources present pending lines that the peripherals have already qualified with their own local enables. Each group passes through its own bit in a mask register. The surviving groups are combined with a global enable and with an in-service flag. The result is a single registered request and the index of the group that should be served.

The in-service flag is set by hardware when the core acknowledges an interrupt. While the flag is set, no further request is raised. A handler may clear the flag by software to allow nesting. Otherwise the return-from-interrupt pulse clears it. The control register also carries a clock-gating disable bit, which leaves the block on a pin and goes to the clock-gating logic outside.

Software reaches the two registers through a one-bit index: index 0 selects the control register and index 1 selects the mask register. Writes are strobed. Reads are combinational and return zero when the read strobe is low.

Top module: `irq_gate_ctrl`

## Requirements
- R1: After reset both registers read 00h, `irqReq` is 0, `irqIdx` is 0 and `clkGateDis` is 0.
- R2: While control bit 0 (global enable) is 0, `irqReq` stays 0 whatever the pending lines and masks are.
- R3: Mask bits 5..0 pass module groups 5..0 and mask bit 7 passes the system group. A group whose mask bit is 0 never causes a request. A request needs a pending, unmasked group, global enable 1 and in-service 0.
- R4: An `ackPulse` sets control bit 1 (in-service) at that clock edge, and it reads back as 1.
- R5: While in-service is 1, `irqReq` is 0.
- R6: A software write of 0 to control bit 1 clears in-service, and a pending unmasked group is then requested again (nesting).
- R7: A `retiPulse` without `ackPulse` clears in-service.
- R8: When `ackPulse` coincides with a software clear of in-service, or with `retiPulse`, in-service ends up 1.
- R9: `clkGateDis` equals control bit 5. A value of 1 disables clock gating.
- R10: The reserved bits always read 0 and ignore writes. These are control bits 7, 6, 4, 3 and 2, and mask bit 6.
- R11: Among the requesting groups, `irqIdx` names the lowest-numbered module (0..5). The system group has index 6 and is picked only when no module group qualifies. `irqIdx` is 0 when `irqReq` is 0.
- R12: `irqReq` and `irqIdx` are registered. After a clock edge they reflect the register contents and pending lines as sampled just before that edge. An `ackPulse` at an edge forces `irqReq` to 0 at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modPend | input | 6 | Pending, locally enabled lines of module groups 5..0 |
| sysPend | input | 1 | Pending line of the system group |
| ackPulse | input | 1 | Core acknowledges an interrupt |
| retiPulse | input | 1 | Return or pop of interrupt state |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regIdx | input | 1 | 0 selects control, 1 selects mask |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data, zero when `regRd` is 0 |
| irqReq | output | 1 | Interrupt request to the core |
| irqIdx | output | 3 | Selected group, 6 for system |
| clkGateDis | output | 1 | Clock-gating disable |

## Verification
Three things can update the in-service flag in the same clock edge: the hardware set from an acknowledge, the hardware clear from a return pulse, and a software write of the control register. The bench drives all three pairings directly. It acknowledges while writing 21h, acknowledges together with a return pulse, and sends a return pulse alone. It then reads control back and compares it with the set-wins order. During the random phase acknowledges, returns and control writes land in the same cycles often, and a bench model that applies the stated priority judges every read and every request.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
  // control register field positions
  localparam int CTRL_IGE = 0;
  localparam int CTRL_INS = 1;
  localparam int CTRL_CGD = 5;
  localparam logic [7:0] CTRL_RW = 8'h23;
  // mask register: system group bit
  localparam int MASK_SYS = 7;
  // register indices
  localparam logic REG_CTRL = 1'b0;
  localparam logic REG_MASK = 1'b1;

  typedef struct packed {
    logic wrCtrl;
    logic wrMask;
    logic setIns;
    logic clrIns;
    logic blockReq;
  } regStrobe_t;
endpackage

// File: rtl/irq_gate_ctl.sv
module irq_gate_ctl
  import irq_gate_pkg::*;
(
  input  logic       regWr,
  input  logic       regIdx,
  input  logic       ackPulse,
  input  logic       retiPulse,
  output regStrobe_t strb
);
  always_comb begin
    strb.wrCtrl   = regWr && (regIdx == REG_CTRL);
    strb.wrMask   = regWr && (regIdx == REG_MASK);
    // hardware set outranks every clear
    strb.setIns   = ackPulse;
    strb.clrIns   = retiPulse && !ackPulse;
    strb.blockReq = ackPulse;
  end
endmodule

// File: rtl/irq_gate_dp.sv
module irq_gate_dp
  import irq_gate_pkg::*;
#(
  parameter int NUM_MOD = 6,
  localparam int NUM_GRP = NUM_MOD + 1,
  localparam int IDX_W = $clog2(NUM_GRP)
) (
  input  logic               clk,
  input  logic               rstN,
  input  regStrobe_t         strb,
  input  logic [NUM_MOD-1:0] modPend,
  input  logic               sysPend,
  input  logic               regRd,
  input  logic               regIdx,
  input  logic [7:0]         regWrData,
  output logic [7:0]         regRdData,
  output logic [7:0]         ctrlQ,
  output logic [7:0]         maskQ,
  output logic               irqReq,
  output logic [IDX_W-1:0]   irqIdx
);
  localparam logic [7:0] MASK_RW = 8'(1 << MASK_SYS) | 8'((1 << NUM_MOD) - 1);

  logic [NUM_GRP-1:0] grpLive;
  logic [IDX_W-1:0]   selIdx;
  logic               reqNext;
  logic               insNext;

  // control register: in-service has its own update priority
  always_comb begin
    insNext = ctrlQ[CTRL_INS];
    if (strb.setIns)      insNext = 1'b1;
    else if (strb.clrIns) insNext = 1'b0;
    else if (strb.wrCtrl) insNext = regWrData[CTRL_INS];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= 8'h00;
    end else begin
      if (strb.wrCtrl) begin
        ctrlQ[CTRL_IGE] <= regWrData[CTRL_IGE];
        ctrlQ[CTRL_CGD] <= regWrData[CTRL_CGD];
      end
      ctrlQ[CTRL_INS] <= insNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            maskQ <= 8'h00;
    else if (strb.wrMask) maskQ <= regWrData & MASK_RW;
  end

  // group qualification: module groups low, system group on top
  generate
    for (genvar g = 0; g < NUM_MOD; g++) begin : g_mod
      assign grpLive[g] = modPend[g] & maskQ[g];
    end
  endgenerate
  assign grpLive[NUM_MOD] = sysPend & maskQ[MASK_SYS];

  // lowest index wins
  always_comb begin
    selIdx = '0;
    for (int i = NUM_GRP - 1; i >= 0; i--) begin
      if (grpLive[i]) selIdx = IDX_W'(i);
    end
  end

  assign reqNext = ctrlQ[CTRL_IGE] && !ctrlQ[CTRL_INS] && !strb.blockReq && (|grpLive);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqReq <= 1'b0;
      irqIdx <= '0;
    end else begin
      irqReq <= reqNext;
      irqIdx <= reqNext ? selIdx : '0;
    end
  end

  always_comb begin
    regRdData = 8'h00;
    if (regRd) regRdData = (regIdx == REG_CTRL) ? ctrlQ : maskQ;
  end
endmodule

// File: rtl/irq_gate_ctrl.sv
module irq_gate_ctrl
  import irq_gate_pkg::*;
#(
  parameter int NUM_MOD = 6,
  localparam int IDX_W = $clog2(NUM_MOD + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_MOD-1:0] modPend,
  input  logic               sysPend,
  input  logic               ackPulse,
  input  logic               retiPulse,
  input  logic               regWr,
  input  logic               regRd,
  input  logic               regIdx,
  input  logic [7:0]         regWrData,
  output logic [7:0]         regRdData,
  output logic               irqReq,
  output logic [IDX_W-1:0]   irqIdx,
  output logic               clkGateDis
);
  regStrobe_t strb;
  logic [7:0] ctrlQ;
  logic [7:0] maskQ;

  irq_gate_ctl u_ctl (
    .regWr     (regWr),
    .regIdx    (regIdx),
    .ackPulse  (ackPulse),
    .retiPulse (retiPulse),
    .strb      (strb)
  );

  irq_gate_dp #(.NUM_MOD(NUM_MOD)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .modPend   (modPend),
    .sysPend   (sysPend),
    .regRd     (regRd),
    .regIdx    (regIdx),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .ctrlQ     (ctrlQ),
    .maskQ     (maskQ),
    .irqReq    (irqReq),
    .irqIdx    (irqIdx)
  );

  assign clkGateDis = ctrlQ[CTRL_CGD];
endmodule

// File: rtl/irq_gate_chk.sv
module irq_gate_chk #(
  parameter int NUM_MOD = 6,
  localparam int IDX_W = $clog2(NUM_MOD + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             ackPulse,
  input logic             retiPulse,
  input logic             irqReq,
  input logic [IDX_W-1:0] irqIdx,
  input logic [7:0]       ctrlQ,
  input logic [7:0]       maskQ
);
  // R2
  ige_off_no_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ctrlQ[0]) |-> !irqReq);

  // R4
  ack_sets_ins_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackPulse |=> ctrlQ[1]);

  // R5
  ins_blocks_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctrlQ[1]) |-> !irqReq);

  // R7
  reti_clears_ins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (retiPulse && !ackPulse) |=> !ctrlQ[1]);

  // R10
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((ctrlQ & 8'hDC) == 8'h00) && !maskQ[6]);

  // R11
  idx_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (int'(irqIdx) <= NUM_MOD));

  // R12
  ack_drops_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackPulse |=> !irqReq);
endmodule

bind irq_gate_ctrl irq_gate_chk #(.NUM_MOD(NUM_MOD)) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .ackPulse  (ackPulse),
  .retiPulse (retiPulse),
  .irqReq    (irqReq),
  .irqIdx    (irqIdx),
  .ctrlQ     (ctrlQ),
  .maskQ     (maskQ)
);

// File: tb/test_irq_gate_ctrl.sv
`timescale 1ns/1ps
module test_irq_gate_ctrl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] modPend = '0;
  logic       sysPend = 1'b0;
  logic       ackPulse = 1'b0;
  logic       retiPulse = 1'b0;
  logic       regWr = 1'b0;
  logic       regRd = 1'b0;
  logic       regIdx = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       irqReq;
  logic [2:0] irqIdx;
  logic       clkGateDis;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_gate_ctrl i_irq_gate_ctrl (
    .clk(clk), .rstN(rstN), .modPend(modPend), .sysPend(sysPend),
    .ackPulse(ackPulse), .retiPulse(retiPulse), .regWr(regWr), .regRd(regRd),
    .regIdx(regIdx), .regWrData(regWrData), .regRdData(regRdData),
    .irqReq(irqReq), .irqIdx(irqIdx), .clkGateDis(clkGateDis)
  );

  // reference model built from the requirements
  logic [7:0] mCtrl = '0, mMask = '0;
  logic       expReq = 0;
  logic [2:0] expIdx = '0;

  function automatic logic [2:0] pickIdx(logic [6:0] live);
    for (int i = 0; i < 7; i++) if (live[i]) return 3'(i);
    return 3'd0;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCtrl = '0; mMask = '0; expReq = 0; expIdx = '0;
    end else begin
      logic [6:0] live;
      logic ins;
      live = {sysPend & mMask[7], modPend & mMask[5:0]};
      expReq = mCtrl[0] && !mCtrl[1] && !ackPulse && (|live);
      expIdx = expReq ? pickIdx(live) : 3'd0;
      ins = mCtrl[1];
      if (ackPulse) ins = 1;
      else if (retiPulse) ins = 0;
      else if (regWr && !regIdx) ins = regWrData[1];
      if (regWr && !regIdx) mCtrl = regWrData & 8'h21;
      mCtrl[1] = ins;
      if (regWr && regIdx) mMask = regWrData & 8'hBF;
    end
  end

  task automatic chk(string tag, int got, int exp);
    compared++;
    if (got != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic checkOut(string tag);
    chk({tag, " req"}, irqReq, expReq);
    chk({tag, " idx"}, irqIdx, expIdx);
    chk({tag, " cgd"}, clkGateDis, mCtrl[5]);
  endtask

  // called at a negedge: apply one cycle of inputs, land at next negedge
  task automatic step(logic [5:0] mp, logic sp, logic ack, logic reti,
                      logic wr, logic idx, logic [7:0] wd);
    modPend = mp; sysPend = sp; ackPulse = ack; retiPulse = reti;
    regWr = wr; regIdx = idx; regWrData = wd;
    @(negedge clk);
    ackPulse = 0; retiPulse = 0; regWr = 0;
  endtask

  task automatic rdReg(logic idx, output logic [7:0] val);
    regRd = 1; regIdx = idx; #1; val = regRdData; regRd = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(modPend, sysPend, 0, 0, 0, 0, 8'h00);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    rdReg(0, v); chk("R1 ctrl", v, 8'h00);
    rdReg(1, v); chk("R1 mask", v, 8'h00);
    chk("R1 req", irqReq, 0); chk("R1 idx", irqIdx, 0); chk("R1 cgd", clkGateDis, 0);

    // R10 mask reserved bit
    step(6'h3F, 1, 0, 0, 1, 1, 8'hFF);
    rdReg(1, v); chk("R10 mask rd", v, 8'hBF);
    idle(2);
    chk("R2 ige off", irqReq, 0);

    // R10 / R9 / R5: all control bits written
    step(6'h3F, 1, 0, 0, 1, 0, 8'hFF);
    rdReg(0, v); chk("R10 ctrl rd", v, 8'h23);
    chk("R9 cgd", clkGateDis, 1);
    idle(2);
    chk("R5 ins blocks", irqReq, 0);

    // R6 software clear of in-service
    step(6'h3F, 1, 0, 0, 1, 0, 8'h21);
    idle(1);
    rdReg(0, v); chk("R6 ins clr", v, 8'h21);
    chk("R6 req again", irqReq, 1);
    chk("R11 idx lowest", irqIdx, 0);

    step(6'b101000, 1, 0, 0, 0, 0, 0); idle(1);
    chk("R11 idx 3", irqIdx, 3);
    step(6'b101000, 1, 0, 0, 1, 1, 8'hF7); idle(1);
    chk("R3 mask blocks 3", irqIdx, 5);
    step(6'h00, 1, 0, 0, 0, 0, 0); idle(1);
    chk("R11 sys idx", irqIdx, 6); chk("R11 sys req", irqReq, 1);
    step(6'h00, 1, 0, 0, 1, 1, 8'h3F); idle(1);
    chk("R3 sys masked", irqReq, 0);
    step(6'h00, 1, 0, 0, 1, 1, 8'hFF); idle(1);
    chk("R3 sys unmasked", irqReq, 1);

    // R12 / R4: acknowledge drops the request at the same edge
    step(6'h00, 1, 1, 0, 0, 0, 0);
    chk("R12 ack drop", irqReq, 0);
    rdReg(0, v); chk("R4 ins set", v, 8'h23);
    idle(1); chk("R5 held off", irqReq, 0);

    // R8 ack with software clear
    step(6'h00, 1, 1, 0, 1, 0, 8'h21);
    rdReg(0, v); chk("R8 ack vs sw", v, 8'h23);
    // R7 return clears
    step(6'h00, 1, 0, 1, 0, 0, 0);
    rdReg(0, v); chk("R7 reti", v, 8'h21);
    idle(1); chk("R7 req back", irqReq, 1);
    // R8 ack with return
    step(6'h00, 1, 1, 1, 0, 0, 0);
    rdReg(0, v); chk("R8 ack vs reti", v, 8'h23);
    idle(1);

    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] wd;
      logic wr, idx, ack, reti;
      wd = 8'($urandom);
      wr = ($urandom % 5) == 0;
      idx = 1'($urandom);
      ack = ($urandom % 7) == 0;
      reti = ($urandom % 6) == 0;
      if (!idx && wr && ($urandom % 2 == 0)) wd[0] = 1;
      regRd = 1'($urandom); regIdx = idx; #1;
      if (regRd) chk("R10 rnd rd", regRdData, idx ? mMask : mCtrl);
      regRd = 0;
      step(6'($urandom), 1'($urandom), ack, reti, wr, idx, wd);
      checkOut("R12 rnd");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule